// File: doc/BRIEF.md
# Multi-encoding signed integer adder

This block adds two N-bit signed operands held in one of three number encodings, chosen per operation: two's complement, ones' complement or sign-magnitude. A subtract control negates the second operand under the chosen encoding's own negation rule before the add. The result comes back in the same encoding, along with an overflow flag and a result-is-zero flag.

Each encoding follows its own arithmetic. Two's complement drops the carry out of the top bit. Ones' complement feeds that carry back into the lowest bit. Sign-magnitude compares the two magnitudes and then either adds or subtracts them. Both zero patterns of the two encodings that have a negative zero are recognised as zero. A parameter selects whether the outputs are registered, which gives one clock of latency (the default), or are driven straight from the combinational datapath.

Top module: `enc_adder`

## Requirements
- R1: `enc_i` selects the encoding: 2'b00 two's complement, 2'b01 ones' complement, 2'b10 sign-magnitude. The reserved value 2'b11 gives exactly the two's complement results.
- R2: In two's complement, `sum_o` equals (a + b) mod 2^N when `sub_i`=0 and (a − b) mod 2^N when `sub_i`=1. The carry out of bit N-1 is discarded.
- R3: In two's complement, `ovf_o` is 1 exactly when the true result lies outside [−2^(N-1), 2^(N-1)−1]. This includes subtracting the most negative value (1 followed by zeros) from a non-negative operand.
- R4: In ones' complement, negation inverts every bit of b, and the carry out of bit N-1 is added back into bit 0. When `ovf_o`=0 the result decodes to the true sum or difference (a value with bit N-1 set decodes as minus the inverted pattern).
- R5: In ones' complement, `ovf_o` is 1 exactly when the true result lies outside ±(2^(N-1)−1). That is the case when the effective operands share a sign and the result's bit N-1 differs from it.
- R6: In sign-magnitude, bit N-1 is the sign (1 = negative) and bits N-2..0 the magnitude, and negation flips bit N-1. Equal signs add the magnitudes and keep the common sign. Unequal signs subtract the smaller magnitude from the larger and take the larger one's sign, and equal magnitudes take a's sign. When `ovf_o`=0 the result decodes to the true value.
- R7: In sign-magnitude, `ovf_o` is 1 exactly when the effective operands share a sign and the sum of their magnitudes reaches 2^(N-1).
- R8: `zero_o` is 1 when the result is all zeros in two's complement, when it is all zeros or all ones in ones' complement, and when bits N-2..0 are zero in sign-magnitude (either sign).
- R9: With registered outputs, results appear one clock after the inputs are presented, and while `rst_ni` is low all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| enc_i | input | 2 | Encoding select |
| sub_i | input | 1 | 1 = subtract b from a |
| sum_o | output | W | Result in the selected encoding |
| ovf_o | output | 1 | True result not representable |
| zero_o | output | 1 | Result is a zero pattern |

## Verification
The only state in the block is the output register, so any fault in the datapath shows up on `sum_o`, `ovf_o` or `zero_o` in the cycle right after the bad operands are presented. Faults do not build up over time. A wrong carry path, negation rule or magnitude comparison tends to hit only a few operand pairs, such as a negative zero, the most negative two's complement value, or two equal magnitudes of opposite sign. For that reason every operand pair, encoding and operation is swept at N=4, and each result is checked against integer arithmetic on that same cycle.

// File: rtl/enc_pkg.sv
package enc_pkg;
  typedef enum logic [1:0] {
    ENC_TWOS = 2'b00,
    ENC_ONES = 2'b01,
    ENC_SMAG = 2'b10,
    ENC_RSVD = 2'b11
  } enc_e;
endpackage

// File: rtl/enc_negate.sv
module enc_negate
  import enc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] b_i,
  input  enc_e         enc_i,
  input  logic         sub_i,
  output logic [W-1:0] b_o,
  output logic         min_neg_o
);
  localparam logic [W-1:0] MinVal = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    b_o       = b_i;
    min_neg_o = 1'b0;
    if (sub_i) begin
      unique case (enc_i)
        ENC_ONES: b_o = ~b_i;
        ENC_SMAG: b_o = {~b_i[W-1], b_i[W-2:0]};
        default: begin
          b_o       = ~b_i + W'(1);
          min_neg_o = (b_i == MinVal);
        end
      endcase
    end
  end
endmodule

// File: rtl/enc_add_core.sv
module enc_add_core
  import enc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  enc_e         enc_i,
  input  logic         min_neg_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  localparam int M = W - 1;

  logic [W:0]   raw;
  logic [M:0]   low;
  logic         c_in, c_out;
  logic [W-1:0] ones_sum;
  logic         ones_ovf, twos_ovf;
  logic [M-1:0] ma, mb, mdiff;
  logic [M:0]   msum;
  logic         a_ge;
  logic [W-1:0] sm_sum;
  logic         sm_ovf;

  assign raw   = {1'b0, a_i} + {1'b0, b_i};
  assign low   = {1'b0, a_i[M-1:0]} + {1'b0, b_i[M-1:0]};
  assign c_in  = low[M];
  assign c_out = raw[W];
  // negating the most negative value flips the meaning of the carry test
  assign twos_ovf = (c_in ^ c_out) ^ min_neg_i;

  // end-around carry; cannot carry a second time
  assign ones_sum = raw[W-1:0] + W'(raw[W]);
  assign ones_ovf = (a_i[M] == b_i[M]) && (ones_sum[M] != a_i[M]);

  assign ma    = a_i[M-1:0];
  assign mb    = b_i[M-1:0];
  assign msum  = {1'b0, ma} + {1'b0, mb};
  assign a_ge  = (ma >= mb);
  assign mdiff = a_ge ? (ma - mb) : (mb - ma);

  always_comb begin
    if (a_i[M] == b_i[M]) begin
      sm_sum = {a_i[M], msum[M-1:0]};
      sm_ovf = msum[M];
    end else begin
      sm_sum = {(a_ge ? a_i[M] : b_i[M]), mdiff};
      sm_ovf = 1'b0;
    end
  end

  always_comb begin
    unique case (enc_i)
      ENC_ONES: begin sum_o = ones_sum;    ovf_o = ones_ovf; end
      ENC_SMAG: begin sum_o = sm_sum;      ovf_o = sm_ovf;   end
      default:  begin sum_o = raw[W-1:0];  ovf_o = twos_ovf; end
    endcase
  end
endmodule

// File: rtl/enc_zero_detect.sv
module enc_zero_detect
  import enc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] sum_i,
  input  enc_e         enc_i,
  output logic         zero_o
);
  always_comb begin
    unique case (enc_i)
      ENC_ONES: zero_o = (sum_i == '0) || (sum_i == '1);
      ENC_SMAG: zero_o = (sum_i[W-2:0] == '0);
      default:  zero_o = (sum_i == '0);
    endcase
  end
endmodule

// File: rtl/enc_out_stage.sv
module enc_out_stage #(
  parameter int W   = 4,
  parameter bit REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sum_i,
  input  logic         ovf_i,
  input  logic         zero_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o,
  output logic         zero_o
);
  if (REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sum_o  <= '0;
        ovf_o  <= 1'b0;
        zero_o <= 1'b0;
      end else begin
        sum_o  <= sum_i;
        ovf_o  <= ovf_i;
        zero_o <= zero_i;
      end
    end
  end else begin : g_comb
    assign sum_o  = sum_i;
    assign ovf_o  = ovf_i;
    assign zero_o = zero_i;
  end
endmodule

// File: rtl/enc_adder.sv
module enc_adder
  import enc_pkg::*;
#(
  parameter int W       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   enc_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o,
  output logic         zero_o
);
  enc_e         enc_sel;
  logic [W-1:0] b_eff, sum_c;
  logic         min_neg, ovf_c, zero_c;

  assign enc_sel = enc_e'(enc_i);

  enc_negate #(.W(W)) u_neg (
    .b_i(b_i), .enc_i(enc_sel), .sub_i(sub_i), .b_o(b_eff), .min_neg_o(min_neg)
  );

  enc_add_core #(.W(W)) u_core (
    .a_i(a_i), .b_i(b_eff), .enc_i(enc_sel), .min_neg_i(min_neg),
    .sum_o(sum_c), .ovf_o(ovf_c)
  );

  enc_zero_detect #(.W(W)) u_zero (
    .sum_i(sum_c), .enc_i(enc_sel), .zero_o(zero_c)
  );

  enc_out_stage #(.W(W), .REG(REG_OUT)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .sum_i(sum_c), .ovf_i(ovf_c), .zero_i(zero_c),
    .sum_o(sum_o), .ovf_o(ovf_o), .zero_o(zero_o)
  );
endmodule

// File: rtl/enc_adder_chk.sv
module enc_adder_chk #(
  parameter int W       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [1:0]   enc_i,
  input logic         sub_i,
  input logic [W-1:0] sum_o,
  input logic         ovf_o,
  input logic         zero_o
);
  localparam int M = W - 1;

  logic [W-1:0] a_d, b_d, tw_exp;
  logic [1:0]   enc_d;
  logic         sub_d, v_d, bs_d;

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_d <= '0; b_d <= '0; enc_d <= '0; sub_d <= 1'b0; v_d <= 1'b0;
      end else begin
        a_d <= a_i; b_d <= b_i; enc_d <= enc_i; sub_d <= sub_i; v_d <= 1'b1;
      end
    end
  end else begin : g_nodly
    assign a_d = a_i; assign b_d = b_i; assign enc_d = enc_i;
    assign sub_d = sub_i; assign v_d = 1'b1;
  end

  assign tw_exp = sub_d ? (a_d - b_d) : (a_d + b_d);
  assign bs_d   = b_d[M] ^ sub_d;

  p_twos_sum_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_d && enc_d == 2'b00) |-> (sum_o == tw_exp));

  p_rsvd_sum_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_d && enc_d == 2'b11) |-> (sum_o == tw_exp));

  p_ones_ovf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_d && enc_d == 2'b01 && a_d[M] == bs_d && sum_o[M] != a_d[M]) |-> ovf_o);

  p_smag_sign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_d && enc_d == 2'b10 && a_d[M] == bs_d && !ovf_o) |-> (sum_o[M] == a_d[M]));

  p_ones_negzero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_d && enc_d == 2'b01 && sum_o == '1) |-> zero_o);

  p_reset_out_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_d |-> (sum_o == '0 && !ovf_o && !zero_o));
endmodule

bind enc_adder enc_adder_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/enc_adder_tb.sv
`timescale 1ns/1ps
module enc_adder_tb;
  localparam int W = 4;

  typedef struct {
    int       enc;
    int       exp_val;
    logic     exp_ovf;
    logic     chk_bits;
    logic [W-1:0] exp_bits;
  } item_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [1:0]   enc_i = '0;
  logic         sub_i = 1'b0;
  logic [W-1:0] sum_o;
  logic         ovf_o, zero_o;

  int    checks = 0, failures = 0;
  bit    done = 1'b0;
  item_t sb_q[$];

  always #4 clk_i = ~clk_i;

  enc_adder #(.W(W), .REG_OUT(1'b1)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .enc_i(enc_i),
    .sub_i(sub_i), .sum_o(sum_o), .ovf_o(ovf_o), .zero_o(zero_o)
  );

  function automatic int dec(logic [W-1:0] x, int e);
    logic [W-1:0] inv;
    inv = ~x;
    case (e)
      1:       return x[W-1] ? -int'(inv) : int'(x);
      2:       return x[W-1] ? -int'(x[W-2:0]) : int'(x[W-2:0]);
      default: return int'($signed(x));
    endcase
  endfunction

  function automatic logic is_zero(logic [W-1:0] x, int e);
    case (e)
      1:       return (x == '0) || (x == '1);
      2:       return x[W-2:0] == '0;
      default: return x == '0;
    endcase
  endfunction

  function automatic string val_tag(int e);
    case (e) 0: return "R2"; 1: return "R4"; 2: return "R6"; default: return "R1"; endcase
  endfunction

  function automatic string ovf_tag(int e);
    case (e) 0: return "R3"; 1: return "R5"; 2: return "R7"; default: return "R1"; endcase
  endfunction

  task automatic drive(int e, logic s, int a, int b);
    item_t it;
    int va, vb, t, lo, hi;
    @(negedge clk_i);
    a_i = W'(a); b_i = W'(b); enc_i = 2'(e); sub_i = s;
    va = dec(W'(a), e);
    vb = dec(W'(b), e);
    t  = s ? va - vb : va + vb;
    hi = (1 << (W-1)) - 1;
    lo = (e == 1 || e == 2) ? -hi : -hi - 1;
    it.enc      = e;
    it.exp_val  = t;
    it.exp_ovf  = (t > hi) || (t < lo);
    it.chk_bits = (e == 0 || e == 3);
    it.exp_bits = W'(t);
    sb_q.push_back(it);
  endtask

  // R9: monitor samples the cycle after the driver, i.e. one-clock latency
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (sb_q.size() > 0) begin
        item_t it;
        logic  ez;
        it = sb_q.pop_front();
        checks++;
        if (ovf_o !== it.exp_ovf) begin
          failures++;
          $display("FAIL %s ovf enc=%0d actual=%0b expected=%0b", ovf_tag(it.enc), it.enc, ovf_o, it.exp_ovf);
        end
        if (!it.exp_ovf) begin
          checks++;
          if (dec(sum_o, it.enc) != it.exp_val) begin
            failures++;
            $display("FAIL %s value enc=%0d actual=%0d expected=%0d", val_tag(it.enc), it.enc, dec(sum_o, it.enc), it.exp_val);
          end
        end
        if (it.chk_bits) begin
          checks++;
          if (sum_o !== it.exp_bits) begin
            failures++;
            $display("FAIL %s bits enc=%0d actual=%b expected=%b", val_tag(it.enc), it.enc, sum_o, it.exp_bits);
          end
        end
        if (it.chk_bits)      ez = is_zero(it.exp_bits, it.enc);
        else if (it.exp_ovf)  ez = is_zero(sum_o, it.enc);
        else                  ez = (it.exp_val == 0);
        checks++;
        if (zero_o !== ez) begin
          failures++;
          $display("FAIL R8 zero enc=%0d sum=%b actual=%0b expected=%0b", it.enc, sum_o, zero_o, ez);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R9 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    a_i = 4'b0111; b_i = 4'b0001;
    repeat (3) @(posedge clk_i);
    #2;
    checks++;
    if (sum_o !== '0 || ovf_o !== 1'b0 || zero_o !== 1'b0) begin
      failures++;
      $display("FAIL R9 reset actual=%b/%0b/%0b expected=0000/0/0", sum_o, ovf_o, zero_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 R2 R3 R4 R5 R6 R7 R8: exhaustive sweep, reserved code included
    for (int e = 0; e < 4; e++)
      for (int s = 0; s < 2; s++)
        for (int a = 0; a < (1 << W); a++)
          for (int b = 0; b < (1 << W); b++)
            drive(e, 1'(s), a, b);
    @(negedge clk_i);
    @(negedge clk_i);
    wait (sb_q.size() == 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule